// File: doc/BRIEF.md
# Post-Configuration Start-Up Sequencer

This block takes a device from the end of configuration into user operation. A one-cycle strobe that marks configuration as complete starts a walk through eight numbered phases, 0 to 7, one phase per sequencer clock. Phase 0 issues a global set/reset pulse that puts every flip-flop in a known state. Three events are each tied to a phase chosen by parameter:

- the DONE output rises;
- the global output-disable signal is released;
- the global write enable for storage elements is granted.

By default these fall at phases 4, 5 and 6. Outputs may therefore drive before any clocked storage changes state.

Two hold points can stall the walk. The first waits at a chosen phase until every selected clock-manager lock flag is high. The second is the sync-to-DONE mode. It keeps the walk from entering the output-release phase until a sensed, shared DONE line is high, so that several devices tied to one wired DONE line leave start-up together. When the walk reaches phase 7 it stays there and raises a completion flag until the next strobe. While running, user logic may force the set/reset and output-disable signals on.

Top module: `startup_seq`

## Requirements
- R1: While reset is held, and after reset until the first accepted strobe, the block is idle. In this state `done_o`=0, `user_io_o`=0, `gts_o`=1 (outputs disabled), `gwe_o`=0 (writes disabled) and `complete_o`=0, and `gsr_o` equals `user_gsr_i`.
- R2: A `cfg_done_i` high sampled at a clock edge while idle or complete puts the walk in phase 0 at that edge. `gsr_o` is high for as long as phase 0 lasts.
- R3: Without holds the phase rises by one at each edge. `done_o` and `user_io_o` are high exactly when the phase is at least DONE_PH (default 4).
- R4: `gts_o` is low exactly when the phase is at least GTS_PH (default 5) and `user_gts_i` is low. `gwe_o` is high exactly when the phase is at least GWE_PH (default 6). The parameters must satisfy GWE_PH >= GTS_PH, so write enable is never granted while outputs are still disabled by the sequence.
- R5: In phase LOCK_PH (default 2), the walk does not advance while any lock flag selected by a 1 bit in `lock_mask_i` is low. It advances at the first edge at which all selected flags are high. A zero mask never holds.
- R6: With `sync_en_i` high, the walk does not advance from phase GTS_PH-1 into GTS_PH while `done_sense_i` is low.
- R7: In phase 7, `complete_o`=1 and the walk stays in phase 7 until a strobe restarts it at phase 0.
- R8: A strobe that arrives while the walk is in phases 0 to 6 has no effect.
- R9: `user_gsr_i` high forces `gsr_o` high, and `user_gts_i` high forces `gts_o` high, in the same cycle and in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_done_i | input | 1 | Configuration-complete strobe |
| lock_i | input | NUM_LOCK | Clock-manager lock flags |
| lock_mask_i | input | NUM_LOCK | Selects which lock flags the lock hold waits for |
| sync_en_i | input | 1 | Enables the sync-to-DONE hold |
| done_sense_i | input | 1 | Sensed level of the shared DONE line |
| user_gsr_i | input | 1 | User request for global set/reset |
| user_gts_i | input | 1 | User request for global output disable |
| done_o | output | 1 | DONE output |
| gts_o | output | 1 | Global output disable, 1 = outputs held off |
| gwe_o | output | 1 | Global write enable, 1 = storage may update |
| gsr_o | output | 1 | Global set/reset |
| user_io_o | output | 1 | Dual-purpose pins are in user-I/O mode |
| complete_o | output | 1 | Start-up sequence has finished |

## Verification
The phase register is the only state, and every sequenced output is decoded from it. A strobe or a hold condition sampled at one rising edge therefore shows up on `done_o`, `gts_o`, `gwe_o`, `gsr_o` and `complete_o` right after that edge, one cycle later. The user overrides act in the same cycle with no register in between. The bench drives inputs and samples outputs only on falling edges. It advances its reference phase at each rising edge from the inputs that were held during that cycle. At each falling edge it compares all outputs against that reference, so every result is checked exactly one edge after the stimulus that caused it.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int unsigned PHASE_W = 3;
  typedef logic [PHASE_W-1:0] phase_t;
  localparam phase_t PHASE_FIRST = '0;
  localparam phase_t PHASE_LAST  = '1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_st_e;

  function automatic logic at_or_past(input phase_t ph, input int unsigned lim);
    return int'(ph) >= int'(lim);
  endfunction
endpackage

// File: rtl/startup_rst_sync.sv
module startup_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/startup_hold.sv
module startup_hold
  import startup_pkg::*;
#(
  parameter int unsigned NUM_LOCK = 2,
  parameter int unsigned LOCK_PH  = 2,
  parameter int unsigned GTS_PH   = 5
) (
  input  seq_st_e             st_i,
  input  phase_t              phase_i,
  input  logic [NUM_LOCK-1:0] lock_i,
  input  logic [NUM_LOCK-1:0] lock_mask_i,
  input  logic                sync_en_i,
  input  logic                done_sense_i,
  output logic                stall_o
);
  localparam phase_t LOCK_AT = phase_t'(LOCK_PH);
  localparam phase_t SYNC_AT = phase_t'(GTS_PH - 1);

  logic [NUM_LOCK-1:0] unmet;
  logic                lock_wait;
  logic                sync_wait;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LOCK; gi++) begin : g_lock
      assign unmet[gi] = lock_mask_i[gi] & ~lock_i[gi];
    end
  endgenerate

  always_comb begin
    lock_wait = (st_i == SEQ_RUN) && (phase_i == LOCK_AT) && (|unmet);
    sync_wait = (st_i == SEQ_RUN) && sync_en_i && (phase_i == SYNC_AT) && !done_sense_i;
    stall_o   = lock_wait | sync_wait;
  end
endmodule

// File: rtl/startup_phase_ctr.sv
module startup_phase_ctr
  import startup_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    stall_i,
  output seq_st_e st_o,
  output phase_t  phase_o
);
  seq_st_e st_q, st_d;
  phase_t  ph_q, ph_d;
  logic    at_end;
  logic    accept;
  logic    step;
  logic    ena;

  always_comb begin
    at_end = (st_q == SEQ_RUN) && (ph_q == PHASE_LAST);
    accept = start_i && ((st_q == SEQ_IDLE) || at_end);
    step   = (st_q == SEQ_RUN) && !at_end && !stall_i;
    ena    = accept | step;
    st_d   = st_q;
    ph_d   = ph_q;
    if (accept) begin
      st_d = SEQ_RUN;
      ph_d = PHASE_FIRST;
    end else if (step) begin
      ph_d = ph_q + phase_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
      ph_q <= PHASE_FIRST;
    end else if (ena) begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign st_o    = st_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/startup_evt_decode.sv
module startup_evt_decode
  import startup_pkg::*;
#(
  parameter int unsigned DONE_PH = 4,
  parameter int unsigned GTS_PH  = 5,
  parameter int unsigned GWE_PH  = 6
) (
  input  seq_st_e st_i,
  input  phase_t  phase_i,
  input  logic    user_gsr_i,
  input  logic    user_gts_i,
  output logic    done_o,
  output logic    gts_o,
  output logic    gwe_o,
  output logic    gsr_o,
  output logic    user_io_o,
  output logic    complete_o
);
  logic running;

  always_comb begin
    running    = (st_i == SEQ_RUN);
    done_o     = running && at_or_past(phase_i, DONE_PH);
    gts_o      = !(running && at_or_past(phase_i, GTS_PH)) || user_gts_i;
    gwe_o      = running && at_or_past(phase_i, GWE_PH);
    gsr_o      = (running && (phase_i == PHASE_FIRST)) || user_gsr_i;
    user_io_o  = done_o;
    complete_o = running && (phase_i == PHASE_LAST);
  end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int unsigned NUM_LOCK = 2,
  parameter int unsigned DONE_PH  = 4,
  parameter int unsigned GTS_PH   = 5,
  parameter int unsigned GWE_PH   = 6,
  parameter int unsigned LOCK_PH  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_done_i,
  input  logic [NUM_LOCK-1:0] lock_i,
  input  logic [NUM_LOCK-1:0] lock_mask_i,
  input  logic                sync_en_i,
  input  logic                done_sense_i,
  input  logic                user_gsr_i,
  input  logic                user_gts_i,
  output logic                done_o,
  output logic                gts_o,
  output logic                gwe_o,
  output logic                gsr_o,
  output logic                user_io_o,
  output logic                complete_o
);
  generate
    if (DONE_PH < 1 || DONE_PH > 6 || GTS_PH < 1 || GTS_PH > 6 ||
        GWE_PH < 1 || GWE_PH > 6 || LOCK_PH > 6 || GWE_PH < GTS_PH ||
        NUM_LOCK < 1) begin : g_bad_cfg
      $error("startup_seq: event phases out of range or write enable before output release");
    end
  endgenerate

  logic    rst_core_n;
  logic    stall;
  seq_st_e st_q;
  phase_t  phase_q;

  startup_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  startup_hold #(
    .NUM_LOCK (NUM_LOCK),
    .LOCK_PH  (LOCK_PH),
    .GTS_PH   (GTS_PH)
  ) u_hold (
    .st_i         (st_q),
    .phase_i      (phase_q),
    .lock_i       (lock_i),
    .lock_mask_i  (lock_mask_i),
    .sync_en_i    (sync_en_i),
    .done_sense_i (done_sense_i),
    .stall_o      (stall)
  );

  startup_phase_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start_i (cfg_done_i),
    .stall_i (stall),
    .st_o    (st_q),
    .phase_o (phase_q)
  );

  startup_evt_decode #(
    .DONE_PH (DONE_PH),
    .GTS_PH  (GTS_PH),
    .GWE_PH  (GWE_PH)
  ) u_dec (
    .st_i       (st_q),
    .phase_i    (phase_q),
    .user_gsr_i (user_gsr_i),
    .user_gts_i (user_gts_i),
    .done_o     (done_o),
    .gts_o      (gts_o),
    .gwe_o      (gwe_o),
    .gsr_o      (gsr_o),
    .user_io_o  (user_io_o),
    .complete_o (complete_o)
  );
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk
  import startup_pkg::*;
#(
  parameter int unsigned NUM_LOCK = 2,
  parameter int unsigned GTS_PH   = 5,
  parameter int unsigned LOCK_PH  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_done_i,
  input logic [NUM_LOCK-1:0] lock_i,
  input logic [NUM_LOCK-1:0] lock_mask_i,
  input logic                sync_en_i,
  input logic                done_sense_i,
  input logic                user_gsr_i,
  input logic                user_gts_i,
  input logic                done_o,
  input logic                gts_o,
  input logic                gwe_o,
  input logic                gsr_o,
  input logic                complete_o,
  input seq_st_e             st_i,
  input phase_t              phase_i
);
  localparam phase_t LOCK_AT = phase_t'(LOCK_PH);
  localparam phase_t SYNC_AT = phase_t'(GTS_PH - 1);

  p_gwe_after_gts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gwe_o |-> (!gts_o || user_gts_i));

  p_start_gsr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done_i && st_i == SEQ_IDLE) |=> gsr_o);

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == SEQ_RUN && phase_i == LOCK_AT && ((lock_i & lock_mask_i) != lock_mask_i))
    |=> (phase_i == LOCK_AT));

  p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == SEQ_RUN && sync_en_i && !done_sense_i && phase_i == SYNC_AT)
    |=> (phase_i == SYNC_AT));

  p_complete_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && !cfg_done_i) |=> complete_o);

  p_complete_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> (done_o && gwe_o));

  p_mid_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == SEQ_RUN && phase_i != PHASE_LAST && phase_i != PHASE_FIRST && cfg_done_i)
    |=> (phase_i != PHASE_FIRST));

  p_user_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (user_gts_i |-> gts_o) and (user_gsr_i |-> gsr_o));
endmodule

bind startup_seq startup_seq_chk #(
  .NUM_LOCK (NUM_LOCK),
  .GTS_PH   (GTS_PH),
  .LOCK_PH  (LOCK_PH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .cfg_done_i   (cfg_done_i),
  .lock_i       (lock_i),
  .lock_mask_i  (lock_mask_i),
  .sync_en_i    (sync_en_i),
  .done_sense_i (done_sense_i),
  .user_gsr_i   (user_gsr_i),
  .user_gts_i   (user_gts_i),
  .done_o       (done_o),
  .gts_o        (gts_o),
  .gwe_o        (gwe_o),
  .gsr_o        (gsr_o),
  .complete_o   (complete_o),
  .st_i         (st_q),
  .phase_i      (phase_q)
);

// File: tb/startup_seq_test.sv
module startup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 2;
  localparam int P_DN = 4;
  localparam int P_TS = 5;
  localparam int P_WE = 6;
  localparam int P_LK = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_done = 1'b0;
  logic [NL-1:0] lock = '0;
  logic [NL-1:0] mask = '0;
  logic sync_en = 1'b0;
  logic sense = 1'b0;
  logic u_gsr = 1'b0;
  logic u_gts = 1'b0;
  logic done_o, gts_o, gwe_o, gsr_o, user_io_o, complete_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  bit m_run;
  int m_ph;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  startup_seq #(
    .NUM_LOCK (NL), .DONE_PH (P_DN), .GTS_PH (P_TS), .GWE_PH (P_WE), .LOCK_PH (P_LK)
  ) uut (
    .clk (clk), .rst_n (rst_n), .cfg_done_i (cfg_done), .lock_i (lock),
    .lock_mask_i (mask), .sync_en_i (sync_en), .done_sense_i (sense),
    .user_gsr_i (u_gsr), .user_gts_i (u_gts), .done_o (done_o), .gts_o (gts_o),
    .gwe_o (gwe_o), .gsr_o (gsr_o), .user_io_o (user_io_o), .complete_o (complete_o)
  );

  // Reference phase from the requirements: R2 start, R3 step, R5/R6 holds, R7/R8 strobes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_ph <= 0; m_tag <= "R1";
    end else if (cfg_done && (!m_run || m_ph == 7)) begin
      m_run <= 1; m_ph <= 0; m_tag <= "R2";
    end else if (m_run && m_ph != 7) begin
      if (m_ph == P_LK && ((lock & mask) != mask)) m_tag <= "R5";
      else if (sync_en && !sense && m_ph == P_TS - 1) m_tag <= "R6";
      else begin
        m_ph <= m_ph + 1;
        m_tag <= cfg_done ? "R8" : "R3";
      end
    end else begin
      m_tag <= m_run ? "R7" : "R1";
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic e_done, e_gts, e_gwe, e_gsr, e_cmp;
    e_done = m_run && m_ph >= P_DN;
    e_gts  = !(m_run && m_ph >= P_TS) || u_gts;
    e_gwe  = m_run && m_ph >= P_WE;
    e_gsr  = (m_run && m_ph == 0) || u_gsr;
    e_cmp  = m_run && m_ph == 7;
    check(m_tag, "done_o", done_o, e_done);
    check(m_tag, "user_io_o", user_io_o, e_done);
    check(u_gts ? "R9" : "R4", "gts_o", gts_o, e_gts);
    check("R4", "gwe_o", gwe_o, e_gwe);
    check(u_gsr ? "R9" : "R2", "gsr_o", gsr_o, e_gsr);
    check("R7", "complete_o", complete_o, e_cmp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step_neg(input logic c, input logic [NL-1:0] lk, input logic s);
    @(negedge clk);
    check_all();
    cfg_done = c; lock = lk; sense = s;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: idle state during and after reset
    repeat (3) @(negedge clk);
    check_all();
    check("R1", "gts_o reset", gts_o, 1'b1);
    check("R1", "gwe_o reset", gwe_o, 1'b0);
    rst_n = 1'b1;
    repeat (6) step_neg(1'b0, '1, 1'b1);
    // R3/R4/R7: plain run with defaults
    step_neg(1'b1, '1, 1'b1);
    repeat (10) step_neg(1'b0, '1, 1'b1);
    check("R7", "complete after plain run", complete_o, 1'b1);
    // R5: lock hold, one selected flag low for a while
    mask = 2'b11;
    step_neg(1'b1, 2'b01, 1'b1);
    repeat (12) step_neg(1'b0, 2'b01, 1'b1);
    check("R5", "done_o while lock held", done_o, 1'b0);
    repeat (8) step_neg(1'b0, 2'b11, 1'b1);
    // R6: sync hold with sense low, then strobe mid sequence (R8)
    sync_en = 1'b1; mask = '0;
    step_neg(1'b1, '0, 1'b0);
    repeat (3) step_neg(1'b1, '0, 1'b0);
    repeat (10) step_neg(1'b0, '0, 1'b0);
    check("R6", "gts_o while sync held", gts_o, 1'b1);
    check("R6", "done_o before sync release", done_o, 1'b1);
    repeat (5) step_neg(1'b0, '0, 1'b1);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic c, s;
      logic [NL-1:0] lk;
      if (i % 200 == 0) begin
        mask = NL'($urandom);
        sync_en = $urandom_range(0, 1);
      end
      c  = ($urandom_range(0, 15) == 0);
      s  = ($urandom_range(0, 2) != 0);
      for (int b = 0; b < NL; b++) lk[b] = ($urandom_range(0, 3) != 0);
      step_neg(c, lk, s);
      u_gsr = ($urandom_range(0, 31) == 0);
      u_gts = ($urandom_range(0, 15) == 0);
    end
    @(negedge clk);
    check_all();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule